// File: doc/BRIEF.md
# Interrupt Response Cycle Sequencer

This block produces the bus cycles a small processor runs when it takes an interrupt. It handles a non-maskable request and a maskable request in three modes. When a request is accepted, the block latches the program counter, the stack pointer, the vector register and the mode. It then runs a fixed series of machine cycles. Each machine cycle lasts a set number of clocks, one clock per T-state.

The series depends on the request type and the mode. A non-maskable request runs an opcode fetch whose byte is thrown away. A maskable request runs an acknowledge cycle. Depending on the mode, the acknowledge cycle may be followed by operand reads of an instruction supplied by the device, or by a pair of vector-table reads. Every series contains two stack writes that save the return address. At the end, the block reports the address of the service routine and the lowered stack pointer.

The states are IDLE, NMIF (ignored fetch), ACK (acknowledge), OPL and OPH (operand low and high), SWH and SWL (stack write high and low), TRL and TRH (table read low and high), and FIN (completion). The transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | non-maskable request | NMIF |
| IDLE | maskable request with enable | ACK |
| NMIF | last T-state | SWH |
| ACK | last T-state, mode 0 with call byte | OPL |
| ACK | last T-state, any other case | SWH |
| OPL | last T-state | OPH |
| OPH | last T-state | SWH |
| SWH | last T-state | SWL |
| SWL | last T-state, table mode | TRL |
| SWL | last T-state, other modes | FIN |
| TRL | last T-state | TRH |
| TRH | last T-state | FIN |
| FIN | always | IDLE |

Top module: `irs_top`

## Requirements
- R1: While reset is low, and in IDLE afterwards, `busy`, `rd`, `wr` and `done` are 0 and `cyc_kind` is 0.
- R2: Requests are sampled only in IDLE. A non-maskable request wins over a maskable one. A maskable request is accepted only when `irq_en` is 1. A request that arrives while a series is running has no effect on it.
- R3: `cyc_kind` codes are IDLE=0, NMIF=1, ACK=2, OPL=3, OPH=4, SWH=5, SWL=6, TRL=7, TRH=8, FIN=9. Each machine cycle holds its code for `t_len` clocks while `t_state` counts 1 to `t_len`.
- R4: A non-maskable request runs NMIF (5 clocks, read at the latched PC, byte ignored), then SWH (3 clocks), then SWL (3 clocks). The new PC is 0x0066.
- R5: Mode 1 runs ACK (7 clocks), SWH and SWL. The new PC is 0x0038.
- R6: Mode 2 runs ACK (7 clocks), SWH, SWL, then TRL (3 clocks) and TRH (3 clocks). The TRL address has the vector register as its high byte and the acknowledge byte with bit 0 cleared as its low byte. The TRH address is the TRL address plus 1. The new PC is {TRH byte, TRL byte}. Mode value 3 behaves as mode 2.
- R7: In mode 0, when the acknowledge byte is 0xCD, the block runs ACK (6 clocks), OPL (3 clocks), OPH (4 clocks), SWH and SWL. The new PC is {OPH byte, OPL byte}.
- R8: In mode 0, when the acknowledge byte is any other value, the block runs ACK (6 clocks), SWH and SWL. The new PC is the acknowledge byte ANDed with 0x38, zero-extended.
- R9: PC and SP are latched at acceptance. SWH writes PC[15:8] to SP-1 and SWL writes PC[7:0] to SP-2, modulo 2^16. The new SP is SP-2.
- R10: `rd` is 1 throughout NMIF, ACK, OPL, OPH, TRL and TRH. `wr` is 1 throughout SWH and SWL. The two are never 1 together.
- R11: `busy` is 1 from the first machine cycle through FIN. `done` pulses for one clock after FIN, with `new_pc` and `new_sp` valid. Both values hold until the next series completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock, one T-state per cycle |
| rst_n | input | 1 | active-low synchronous reset |
| nmi_req | input | 1 | non-maskable request |
| irq_req | input | 1 | maskable request |
| irq_en | input | 1 | maskable request enable |
| irq_mode | input | 2 | maskable response mode |
| vec_reg | input | 8 | vector register (table high byte) |
| pc_in | input | 16 | current program counter |
| sp_in | input | 16 | current stack pointer |
| data_in | input | 8 | read data from device or memory |
| busy | output | 1 | series in progress |
| cyc_kind | output | 4 | machine-cycle tag |
| t_state | output | 3 | T-state index within cycle, 0 when idle |
| t_len | output | 3 | length of current cycle, 0 when idle |
| addr | output | 16 | bus address |
| wdata | output | 8 | write data |
| rd | output | 1 | read strobe |
| wr | output | 1 | write strobe |
| done | output | 1 | completion pulse |
| new_pc | output | 16 | service routine address |
| new_sp | output | 16 | stack pointer after the pushes |

## Verification
The bench targets these corner cases:

- **Mode 0 acknowledge length.** The mode 0 acknowledge lasts 6 clocks, and the other modes use 7. A design that used one length for all modes would show a wrong clock count and a wrong length sequence.
- **Call versus restart.** A design that confused the call byte with a restart byte would skip or add the operand reads and jump to the wrong address.
- **Table index with an odd acknowledge byte.** A design that left bit 0 of the acknowledge byte set would fetch the table entry from the wrong address.
- **Mode value 3.** This value must behave as mode 2.
- **Stack pointer wrap below zero.** A stack pointer of 0x0000 or 0x0001 checks that the pushes wrap modulo 2^16.
- **Priority and gating of requests.**
  - A non-maskable request arriving together with a maskable one must run the non-maskable series.
  - A gated-off maskable request must not start a series.
  - A request arriving in the middle of a series must not restart or extend it.
- **Latching at acceptance.** `pc_in`, `sp_in`, `vec_reg` and `irq_mode` are changed right after acceptance. A design that did not latch them would push or index with the wrong values.

// File: rtl/irs_pkg.sv
package irs_pkg;

    localparam int unsigned TW = 3;

    typedef enum logic [3:0] {
        PH_IDLE = 4'd0,
        PH_NMIF = 4'd1,
        PH_ACK  = 4'd2,
        PH_OPL  = 4'd3,
        PH_OPH  = 4'd4,
        PH_SWH  = 4'd5,
        PH_SWL  = 4'd6,
        PH_TRL  = 4'd7,
        PH_TRH  = 4'd8,
        PH_FIN  = 4'd9
    } phase_t;

    typedef enum logic [2:0] {
        RT_NMI = 3'd0,
        RT_M1  = 3'd1,
        RT_M2  = 3'd2,
        RT_M0R = 3'd3,
        RT_M0C = 3'd4
    } route_t;

    localparam logic [TW-1:0] LEN_FETCH   = 3'd5;
    localparam logic [TW-1:0] LEN_ACK_M0  = 3'd6;
    localparam logic [TW-1:0] LEN_ACK_VEC = 3'd7;
    localparam logic [TW-1:0] LEN_SHORT   = 3'd3;
    localparam logic [TW-1:0] LEN_OPH     = 3'd4;

    function automatic logic [TW-1:0] phase_len(phase_t ph, route_t rt);
        logic [TW-1:0] n;
        case (ph)
            PH_NMIF: n = LEN_FETCH;
            PH_ACK:  n = (rt == RT_M0R || rt == RT_M0C) ? LEN_ACK_M0 : LEN_ACK_VEC;
            PH_OPH:  n = LEN_OPH;
            PH_OPL, PH_SWH, PH_SWL, PH_TRL, PH_TRH: n = LEN_SHORT;
            default: n = '0;
        endcase
        return n;
    endfunction

    function automatic logic phase_is_read(phase_t ph);
        return (ph == PH_NMIF) || (ph == PH_ACK) || (ph == PH_OPL) ||
               (ph == PH_OPH)  || (ph == PH_TRL) || (ph == PH_TRH);
    endfunction

    function automatic logic phase_is_write(phase_t ph);
        return (ph == PH_SWH) || (ph == PH_SWL);
    endfunction

    function automatic logic phase_runs(phase_t ph);
        return (ph != PH_IDLE) && (ph != PH_FIN);
    endfunction

endpackage

// File: rtl/irs_tstate.sv
module irs_tstate #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] len,
    output logic [W-1:0] t_state,
    output logic         last
);

    localparam logic [W-1:0] FIRST = W'(1);

    logic [W-1:0] t_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= FIRST;
        end else if (!run || last) begin
            t_q <= FIRST;
        end else begin
            t_q <= t_q + FIRST;
        end
    end

    assign last    = run && (t_q == len);
    assign t_state = t_q;

    // R3: the count stays inside 1..len while a cycle runs
    p_tstate_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (t_q >= FIRST) && (t_q <= len));

    // R3: a cycle that has not reached its end advances by one
    p_tstate_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !last) |=> (t_q == $past(t_q) + FIRST));

endmodule

// File: rtl/irs_seq_fsm.sv
module irs_seq_fsm
    import irs_pkg::*;
#(
    parameter logic [7:0] CALL_OP = 8'hCD
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_req,
    input  logic       irq_req,
    input  logic       irq_en,
    input  logic [1:0] mode,
    input  logic [7:0] data_in,
    input  logic       last,
    output phase_t     phase,
    output route_t     route,
    output logic       accept
);

    phase_t phase_q, phase_nx;
    route_t route_q, route_nx;
    logic   is_call;

    assign is_call = (data_in == CALL_OP);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            route_q <= RT_NMI;
        end else begin
            phase_q <= phase_nx;
            route_q <= route_nx;
        end
    end

    // next-state logic
    always_comb begin
        phase_nx = phase_q;
        route_nx = route_q;
        unique case (phase_q)
            PH_IDLE: begin
                if (nmi_req) begin
                    phase_nx = PH_NMIF;
                    route_nx = RT_NMI;
                end else if (irq_req && irq_en) begin
                    phase_nx = PH_ACK;
                    if (mode[1])         route_nx = RT_M2;
                    else if (mode[0])    route_nx = RT_M1;
                    else                 route_nx = RT_M0R;
                end
            end
            PH_NMIF: if (last) phase_nx = PH_SWH;
            PH_ACK: begin
                if (last) begin
                    if (route_q == RT_M0R && is_call) begin
                        phase_nx = PH_OPL;
                        route_nx = RT_M0C;
                    end else begin
                        phase_nx = PH_SWH;
                    end
                end
            end
            PH_OPL:  if (last) phase_nx = PH_OPH;
            PH_OPH:  if (last) phase_nx = PH_SWH;
            PH_SWH:  if (last) phase_nx = PH_SWL;
            PH_SWL:  if (last) phase_nx = (route_q == RT_M2) ? PH_TRL : PH_FIN;
            PH_TRL:  if (last) phase_nx = PH_TRH;
            PH_TRH:  if (last) phase_nx = PH_FIN;
            PH_FIN:  phase_nx = PH_IDLE;
            default: phase_nx = PH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        phase  = phase_q;
        route  = route_q;
        accept = (phase_q == PH_IDLE) && (phase_nx != PH_IDLE);
    end

    // R2: non-maskable request wins in idle
    p_nmi_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && nmi_req) |=> (phase_q == PH_NMIF));

    // R2: maskable request without enable leaves the block idle
    p_irq_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && !nmi_req && !irq_en) |=> (phase_q == PH_IDLE));

    // R2: the route chosen at acceptance is not disturbed mid-series
    p_route_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE && phase_q != PH_ACK) |=> $stable(route_q));

    // R9: the low stack write always follows the high one
    p_swh_then_swl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_SWH && last) |=> (phase_q == PH_SWL));

endmodule

// File: rtl/irs_bus_unit.sv
module irs_bus_unit
    import irs_pkg::*;
#(
    parameter int unsigned  AW       = 16,
    parameter int unsigned  DW       = 8,
    parameter logic [15:0]  NMI_PC   = 16'h0066,
    parameter logic [15:0]  FIX_PC   = 16'h0038,
    parameter logic [7:0]   RST_MASK = 8'h38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  phase_t        phase,
    input  route_t        route,
    input  logic          last,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] vec_in,
    input  logic [DW-1:0] data_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rd,
    output logic          wr,
    output logic [AW-1:0] new_pc,
    output logic [AW-1:0] new_sp
);

    localparam logic [AW-1:0] ONE   = AW'(1);
    localparam logic [AW-1:0] TWO   = AW'(2);
    localparam logic [DW-1:0] EVEN  = ~(DW'(1));

    logic [AW-1:0] pc_q, sp_q, npc_q, nsp_q, tbl_addr;
    logic [DW-1:0] vec_q, ack_q, lo_q, hi_q;
    logic [AW-1:0] pc_pick;

    // latch context at acceptance, capture read bytes on the last T-state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q  <= '0;
            sp_q  <= '0;
            vec_q <= '0;
            ack_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (accept) begin
                pc_q  <= pc_in;
                sp_q  <= sp_in;
                vec_q <= vec_in;
            end
            if (last) begin
                unique case (phase)
                    PH_ACK:          ack_q <= data_in;
                    PH_OPL, PH_TRL:  lo_q  <= data_in;
                    PH_OPH, PH_TRH:  hi_q  <= data_in;
                    default: ;
                endcase
            end
        end
    end

    assign tbl_addr = {vec_q, ack_q & EVEN};

    always_comb begin
        unique case (route)
            RT_NMI:  pc_pick = NMI_PC;
            RT_M1:   pc_pick = FIX_PC;
            RT_M0R:  pc_pick = AW'(ack_q & RST_MASK);
            default: pc_pick = {hi_q, lo_q};
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            npc_q <= '0;
            nsp_q <= '0;
        end else if (phase == PH_FIN) begin
            npc_q <= pc_pick;
            nsp_q <= sp_q - TWO;
        end
    end

    // bus drive per phase
    always_comb begin
        addr  = '0;
        wdata = '0;
        unique case (phase)
            PH_NMIF, PH_ACK, PH_OPL, PH_OPH: addr = pc_q;
            PH_SWH: begin
                addr  = sp_q - ONE;
                wdata = pc_q[AW-1:DW];
            end
            PH_SWL: begin
                addr  = sp_q - TWO;
                wdata = pc_q[DW-1:0];
            end
            PH_TRL:  addr = tbl_addr;
            PH_TRH:  addr = tbl_addr | ONE;
            default: ;
        endcase
        rd = phase_is_read(phase);
        wr = phase_is_write(phase);
    end

    assign new_pc = npc_q;
    assign new_sp = nsp_q;

    // R10: strobes are never both high
    p_rdwr_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd && wr));

    // R9: the second push lands one below the first
    p_sp_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_SWL && $past(phase) == PH_SWH) |-> (addr == $past(addr) - ONE));

    // R6: the high table byte is read one above the low one
    p_tbl_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_TRH && $past(phase) == PH_TRL) |-> (addr == $past(addr) + ONE));

    // R11: results only change when a series completes
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_FIN) |=> $stable(npc_q));

endmodule

// File: rtl/irs_top.sv
module irs_top
    import irs_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned DW       = 8,
    parameter logic [15:0] NMI_PC   = 16'h0066,
    parameter logic [15:0] FIX_PC   = 16'h0038,
    parameter logic [7:0]  CALL_OP  = 8'hCD,
    parameter logic [7:0]  RST_MASK = 8'h38
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          nmi_req,
    input  logic          irq_req,
    input  logic          irq_en,
    input  logic [1:0]    irq_mode,
    input  logic [DW-1:0] vec_reg,
    input  logic [AW-1:0] pc_in,
    input  logic [AW-1:0] sp_in,
    input  logic [DW-1:0] data_in,
    output logic          busy,
    output logic [3:0]    cyc_kind,
    output logic [TW-1:0] t_state,
    output logic [TW-1:0] t_len,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wdata,
    output logic          rd,
    output logic          wr,
    output logic          done,
    output logic [AW-1:0] new_pc,
    output logic [AW-1:0] new_sp
);

    phase_t        phase;
    route_t        route;
    logic          accept, last, run, done_q;
    logic [TW-1:0] len, t_raw;

    assign run = phase_runs(phase);
    assign len = phase_len(phase, route);

    irs_seq_fsm #(.CALL_OP(CALL_OP)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_req (nmi_req),
        .irq_req (irq_req),
        .irq_en  (irq_en),
        .mode    (irq_mode),
        .data_in (data_in),
        .last    (last),
        .phase   (phase),
        .route   (route),
        .accept  (accept)
    );

    irs_tstate #(.W(TW)) u_tcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .len     (len),
        .t_state (t_raw),
        .last    (last)
    );

    irs_bus_unit #(
        .AW       (AW),
        .DW       (DW),
        .NMI_PC   (NMI_PC),
        .FIX_PC   (FIX_PC),
        .RST_MASK (RST_MASK)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .phase   (phase),
        .route   (route),
        .last    (last),
        .pc_in   (pc_in),
        .sp_in   (sp_in),
        .vec_in  (vec_reg),
        .data_in (data_in),
        .addr    (addr),
        .wdata   (wdata),
        .rd      (rd),
        .wr      (wr),
        .new_pc  (new_pc),
        .new_sp  (new_sp)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= (phase == PH_FIN);
    end

    assign busy     = (phase != PH_IDLE);
    assign cyc_kind = phase;
    assign t_state  = run ? t_raw : '0;
    assign t_len    = len;
    assign done     = done_q;

    // R1: nothing is strobed while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!rd && !wr));

    // R11: the completion pulse arrives with the sequencer back in idle
    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cyc_kind == 4'd0));

    // R11: completion is a single-clock pulse
    p_done_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: tb/irs_top_test.sv
module irs_top_test;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi_req = 1'b0, irq_req = 1'b0, irq_en = 1'b0;
    logic [1:0]  irq_mode = 2'd0;
    logic [7:0]  vec_reg = 8'h00;
    logic [15:0] pc_in = 16'h0000, sp_in = 16'h0000;
    logic [7:0]  data_in;
    logic        busy, rd, wr, done;
    logic [3:0]  cyc_kind;
    logic [2:0]  t_state, t_len;
    logic [15:0] addr, new_pc, new_sp;
    logic [7:0]  wdata;

    logic [7:0]  cur_ack = 8'h00, cur_opl = 8'h00, cur_oph = 8'h00;
    int          total = 0, bad = 0;

    always #(PERIOD/2) clk = ~clk;

    irs_top uut (
        .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .irq_req(irq_req),
        .irq_en(irq_en), .irq_mode(irq_mode), .vec_reg(vec_reg),
        .pc_in(pc_in), .sp_in(sp_in), .data_in(data_in), .busy(busy),
        .cyc_kind(cyc_kind), .t_state(t_state), .t_len(t_len), .addr(addr),
        .wdata(wdata), .rd(rd), .wr(wr), .done(done), .new_pc(new_pc),
        .new_sp(new_sp)
    );

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'hA5;
    endfunction

    // bus model: device answers acknowledge and operands, memory answers table reads
    always_comb begin
        case (cyc_kind)
            4'd1:    data_in = 8'hCD;
            4'd2:    data_in = cur_ack;
            4'd3:    data_in = cur_opl;
            4'd4:    data_in = cur_oph;
            4'd7,
            4'd8:    data_in = mem_at(addr);
            default: data_in = 8'h00;
        endcase
    end

    typedef struct packed {
        logic        nmi;
        logic        irq;
        logic        en;
        logic        inj;
        logic [1:0]  mode;
        logic [7:0]  vec;
        logic [15:0] pc;
        logic [15:0] sp;
        logic [7:0]  ack;
        logic [7:0]  opl;
        logic [7:0]  oph;
        logic [23:0] kinds;
        logic [23:0] lens;
    } row_t;

    localparam int NROWS = 9;
    localparam row_t ROWS [NROWS] = '{
        '{1'b1,1'b1,1'b1,1'b0,2'd2,8'h40,16'h1234,16'h8000,8'h00,8'h00,8'h00,24'h000651,24'h000335},
        '{1'b0,1'b1,1'b1,1'b0,2'd1,8'h00,16'hABCD,16'h0000,8'h00,8'h00,8'h00,24'h000652,24'h000337},
        '{1'b0,1'b1,1'b1,1'b0,2'd2,8'h40,16'h0100,16'hFF00,8'h17,8'h00,8'h00,24'h087652,24'h033337},
        '{1'b0,1'b1,1'b1,1'b0,2'd3,8'h81,16'h2222,16'h0001,8'hA2,8'h00,8'h00,24'h087652,24'h033337},
        '{1'b0,1'b1,1'b1,1'b0,2'd0,8'h00,16'h5678,16'hC000,8'hCD,8'h34,8'h12,24'h065432,24'h033436},
        '{1'b0,1'b1,1'b1,1'b0,2'd0,8'h00,16'h0F0F,16'h4000,8'hEF,8'h00,8'h00,24'h000652,24'h000336},
        '{1'b0,1'b1,1'b1,1'b0,2'd0,8'h00,16'h3131,16'h2000,8'hFF,8'h00,8'h00,24'h000652,24'h000336},
        '{1'b0,1'b1,1'b1,1'b0,2'd0,8'h00,16'h4242,16'h1000,8'h00,8'h00,8'h00,24'h000652,24'h000336},
        '{1'b0,1'b1,1'b1,1'b1,2'd1,8'h00,16'h7777,16'h9000,8'h00,8'h00,8'h00,24'h000652,24'h000337}
    };

    function automatic logic [15:0] exp_pc(input row_t r);
        logic [15:0] a;
        if (r.nmi)                 return 16'h0066;              // R4
        if (r.mode == 2'd1)        return 16'h0038;              // R5
        if (r.mode[1]) begin                                     // R6
            a = {r.vec, r.ack & 8'hFE};
            return {mem_at(a + 16'd1), mem_at(a)};
        end
        if (r.ack == 8'hCD)        return {r.oph, r.opl};        // R7
        return {8'h00, r.ack & 8'h38};                           // R8
    endfunction

    function automatic int sum_lens(input logic [23:0] l);
        int s = 0;
        for (int i = 0; i < 6; i++) s += int'(l[4*i +: 4]);
        return s;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] got,
                         input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic run_row(input row_t r);
        logic [23:0] gk = '0, gl = '0;
        logic [15:0] wa [2];
        logic [7:0]  wd [2];
        int n = 0, nw = 0, busy_n = 0, guard = 0, prev_t = 0, prev_len = 0;
        bit tok = 1'b1, sok = 1'b1, er, ew;
        wa[0] = '0; wa[1] = '0; wd[0] = '0; wd[1] = '0;
        @(negedge clk);
        cur_ack = r.ack; cur_opl = r.opl; cur_oph = r.oph;
        irq_mode = r.mode; vec_reg = r.vec; pc_in = r.pc; sp_in = r.sp;
        nmi_req = r.nmi; irq_req = r.irq; irq_en = r.en;
        @(negedge clk);
        nmi_req = 1'b0; irq_req = 1'b0;
        pc_in = 16'hDEAD; sp_in = 16'hBEEF; vec_reg = 8'hEE; irq_mode = ~r.mode;
        while (!done && guard < 80) begin
            nmi_req = 1'b0;
            if (busy) begin
                busy_n++;
                if (cyc_kind != 4'd9) begin
                    if (t_state == 3'd1) begin
                        if (prev_t != 0 && prev_t != prev_len) tok = 1'b0;
                        if (n < 6) begin
                            gk |= 24'(cyc_kind) << (4*n);
                            gl |= 24'(t_len) << (4*n);
                        end
                        n++;
                    end else if (int'(t_state) != prev_t + 1) tok = 1'b0;
                    prev_t = int'(t_state); prev_len = int'(t_len);
                    er = (cyc_kind inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd7, 4'd8});
                    ew = (cyc_kind inside {4'd5, 4'd6});
                    if (rd != er || wr != ew) sok = 1'b0;
                    if (wr && t_state == 3'd1 && nw < 2) begin
                        wa[nw] = addr; wd[nw] = wdata; nw++;
                    end
                end else prev_t = 0;
                if (r.inj && busy_n == 4) nmi_req = 1'b1; // R2: late request
            end
            @(negedge clk);
            guard++;
        end
        nmi_req = 1'b0;
        check(gk == r.kinds, "R3 kind sequence", 32'(gk), 32'(r.kinds));
        check(gl == r.lens, "R4-cycle lengths R5 R7 R8", 32'(gl), 32'(r.lens));
        check(busy_n == sum_lens(r.lens) + 1, "R11 busy clocks", busy_n, sum_lens(r.lens) + 1);
        check(tok, "R3 t_state progression", 32'(tok), 1);
        check(sok, "R10 strobe per cycle", 32'(sok), 1);
        check(wa[0] == r.sp - 16'd1 && wd[0] == r.pc[15:8], "R9 high push",
              {wa[0], 8'h00, wd[0]}, {r.sp - 16'd1, 8'h00, r.pc[15:8]});
        check(wa[1] == r.sp - 16'd2 && wd[1] == r.pc[7:0], "R9 low push",
              {wa[1], 8'h00, wd[1]}, {r.sp - 16'd2, 8'h00, r.pc[7:0]});
        check(new_pc == exp_pc(r), r.nmi ? "R4 nmi target" : (r.mode[1] ? "R6 table target" :
              (r.mode == 2'd1 ? "R5 fixed target" : "R7 R8 mode0 target")),
              32'(new_pc), 32'(exp_pc(r)));
        check(new_sp == r.sp - 16'd2, "R9 new sp", 32'(new_sp), 32'(r.sp - 16'd2));
    endtask

    task automatic finish_up;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; bad++;
        $display("FAIL watchdog expired got=0 exp=1");
        finish_up();
    end

    initial begin
        logic [15:0] hold;
        bit quiet;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!busy && !rd && !wr && !done && cyc_kind == 4'd0, "R1 in reset",
              {busy, rd, wr, done, cyc_kind}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !rd && !wr && !done && cyc_kind == 4'd0 && t_state == 3'd0,
              "R1 after reset", {busy, rd, wr, done, cyc_kind}, 0);

        // R2: gated maskable request
        irq_mode = 2'd1; irq_en = 1'b0; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        quiet = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (busy || rd || wr) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R2 disabled request ignored", 32'(quiet), 1);

        // table of scenarios
        for (int i = 0; i < NROWS; i++) run_row(ROWS[i]);

        // R2: the late request injected in the last row must not restart anything
        repeat (3) @(negedge clk);
        check(!busy, "R2 mid-series request dropped", 32'(busy), 0);

        // R11: results hold while idle
        hold = new_pc;
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            if (new_pc != hold || done) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R11 result held", 32'(new_pc), 32'(hold));

        // R1: reset mid-series returns to idle
        @(negedge clk);
        irq_en = 1'b1; irq_mode = 2'd2; irq_req = 1'b1;
        @(negedge clk);
        irq_req = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(!busy && !rd && !wr && cyc_kind == 4'd0, "R1 reset aborts",
              {busy, rd, wr, cyc_kind}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        finish_up();
    end

endmodule